// File: doc/BRIEF.md
# Bidirectional Mailbox Interrupt Controller

This block carries 32-bit messages between a host-side register port and a local add-on-side register port. There is one mailbox for each direction. The host writes the host-to-local mailbox and the local side reads it. The local side writes the local-to-host mailbox and the host reads it. Each port is a simple synchronous register interface with a strobe, a write flag, a one-bit address (0 selects the mailbox, 1 selects the side's own control register) and a byte-enable per lane. Read data is combinational from the addressed register.

There are four interrupt sources. Each one watches a single byte lane of one mailbox, and software picks that lane. Two sources belong to the host: one fires when the local side reads the host-to-local mailbox, the other when the local side writes the local-to-host mailbox. Two sources belong to the local side: one fires when the host writes the host-to-local mailbox, the other when the host reads the local-to-host mailbox. Every source is a two-state machine, `SRC_IDLE` and `SRC_PEND`. A lane hit moves it from `SRC_IDLE` to `SRC_PEND`. A write-one-clear with no hit in the same cycle moves it back. A second two-state machine on each side, `LINE_QUIET` and `LINE_ACTIVE`, drives the active-low interrupt line. It moves to `LINE_ACTIVE` when any enabled source on that side is pending and returns to `LINE_QUIET` when none is.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset, both mailboxes read zero, both control registers read zero, and `h_irq_n` and `l_irq_n` are high.
- R2: A mailbox write (address 0) stores only the bytes whose byte-enable is set and leaves the other bytes unchanged. The host writes the host-to-local mailbox, which the local side reads at address 0. The local side writes the local-to-host mailbox, which the host reads at address 0.
- R3: Host control register layout: bits 1:0 select the lane for the host-out source (local reads lane), bit 4 enables it, bits 9:8 select the lane for the host-in source (local writes lane), bit 12 enables it, bit 16 is host-out pending, bit 17 is host-in pending, and all other bits read 0. Byte-enable 0 writes bits 1:0 and 4. Byte-enable 1 writes bits 9:8 and 12. Both can change in one write.
- R4: Local control register layout: bits 1:0 and bit 4 hold the lane and enable of the local-in source (host writes lane), bits 9:8 and bit 12 hold those of the local-out source (host reads lane), bit 16 is local-in pending, bit 17 is local-out pending, and the byte-enable rules of R3 apply.
- R5: A local-side mailbox read whose byte-enable covers the lane selected by host bits 1:0 sets host bit 16. A read that misses that lane does not set it.
- R6: A local-side mailbox write covering the lane selected by host bits 9:8 sets host bit 17.
- R7: A host mailbox write covering the lane in local bits 1:0 sets local bit 16. A host mailbox read covering the lane in local bits 9:8 sets local bit 17.
- R8: A pending bit is set by its lane event whether or not its source is enabled, and it stays set until it is cleared.
- R9: A control write with byte-enable 2 set clears each pending bit written as 1. A 0 leaves the bit alone. If a lane event for a source happens in the same cycle as its clear, the bit stays set.
- R10: Each interrupt line is a register. It is low one clock after any source on its side is both pending and enabled, and high one clock after none is.
- R11: Control register accesses, and any access with the strobe low, never set a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_en | input | 1 | Host access strobe |
| h_wr | input | 1 | Host write (1) or read (0) |
| h_addr | input | 1 | Host address: 0 mailbox, 1 control |
| h_be | input | 4 | Host byte-enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational) |
| l_en | input | 1 | Local access strobe |
| l_wr | input | 1 | Local write (1) or read (0) |
| l_addr | input | 1 | Local address: 0 mailbox, 1 control |
| l_be | input | 4 | Local byte-enables |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data (combinational) |
| h_irq_n | output | 1 | Host interrupt, active low |
| l_irq_n | output | 1 | Local interrupt, active low |

## Verification
Read data is due in the same cycle as the read strobe, so the bench checks it one time unit after driving inputs at the falling edge. It compares against a model that holds the state as of the previous rising edge. Mailbox bytes, control fields and pending bits change at the rising edge of the access, so they show up in reads from the next cycle. The interrupt line follows one edge later still, because it is registered from the pending and enable state that held before that edge. The bench checks it one time unit after each rising edge against a value it computed before applying the edge's updates to its model.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    typedef enum logic {
        SRC_IDLE = 1'b0,
        SRC_PEND = 1'b1
    } src_state_t;

    typedef enum logic {
        LINE_QUIET  = 1'b0,
        LINE_ACTIVE = 1'b1
    } line_state_t;

    // source indices: two host-side sources, then two local-side sources
    localparam int SRC_HOST_OUT = 0;
    localparam int SRC_HOST_IN  = 1;
    localparam int SRC_LOC_IN   = 2;
    localparam int SRC_LOC_OUT  = 3;
    localparam int NUM_SRC      = 4;

    // control register field positions (mirrored between sides)
    localparam int LO_SEL_LSB = 0;
    localparam int LO_EN_BIT  = 4;
    localparam int HI_SEL_LSB = 8;
    localparam int HI_EN_BIT  = 12;
    localparam int ST_LO_BIT  = 16;
    localparam int ST_HI_BIT  = 17;

    localparam logic ADDR_MBOX = 1'b0;
    localparam logic ADDR_CTRL = 1'b1;

endpackage

// File: rtl/mbx_irq_src.sv
module mbx_irq_src
    import mbx_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic clr_i,
    output logic pend_o
);

    src_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_IDLE: if (hit_i) state_d = SRC_PEND;
            SRC_PEND: if (clr_i && !hit_i) state_d = SRC_IDLE;
            default:  state_d = SRC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend_o = (state_q == SRC_PEND);
    end

    AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> pend_o); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> pend_o); // R8
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit_i) |=> !pend_o); // R9

endmodule

// File: rtl/mbx_irq_line.sv
module mbx_irq_line
    import mbx_irq_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pend_i,
    input  logic [N_SRC-1:0] en_i,
    output logic             irq_n
);

    line_state_t state_q, state_d;
    logic        any_live;

    always_comb begin
        any_live = |(pend_i & en_i);
        state_d  = state_q;
        unique case (state_q)
            LINE_QUIET:  if (any_live)  state_d = LINE_ACTIVE;
            LINE_ACTIVE: if (!any_live) state_d = LINE_QUIET;
            default:     state_d = LINE_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q == LINE_QUIET);
    end

    AST_IRQ_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_i & en_i)) |=> !irq_n); // R10
    AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend_i & en_i)) |=> irq_n); // R10

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h_en,
    input  logic              h_wr,
    input  logic              h_addr,
    input  logic [DATA_W/8-1:0] h_be,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic              l_addr,
    input  logic [DATA_W/8-1:0] l_be,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              h_irq_n,
    output logic              l_irq_n
);

    localparam int NB    = DATA_W / 8;
    localparam int SEL_W = $clog2(NB);

    // access decode
    logic h_mb_wr, h_mb_rd, h_ct_wr, l_mb_wr, l_mb_rd, l_ct_wr;
    always_comb begin
        h_mb_wr = h_en &&  h_wr && (h_addr == ADDR_MBOX);
        h_mb_rd = h_en && !h_wr && (h_addr == ADDR_MBOX);
        h_ct_wr = h_en &&  h_wr && (h_addr == ADDR_CTRL);
        l_mb_wr = l_en &&  l_wr && (l_addr == ADDR_MBOX);
        l_mb_rd = l_en && !l_wr && (l_addr == ADDR_MBOX);
        l_ct_wr = l_en &&  l_wr && (l_addr == ADDR_CTRL);
    end

    // mailboxes, one register per byte lane
    logic [DATA_W-1:0] h2l_q, l2h_q;

    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [7:0] h2l_b, l2h_b;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                h2l_b <= '0;
                l2h_b <= '0;
            end else begin
                if (h_mb_wr && h_be[b]) h2l_b <= h_wdata[8*b +: 8];
                if (l_mb_wr && l_be[b]) l2h_b <= l_wdata[8*b +: 8];
            end
        end
        assign h2l_q[8*b +: 8] = h2l_b;
        assign l2h_q[8*b +: 8] = l2h_b;
    end

    // per-source control fields, event detection and pending machine
    logic [NUM_SRC-1:0][SEL_W-1:0] sel_q;
    logic [NUM_SRC-1:0]            en_q;
    logic [NUM_SRC-1:0]            hit;
    logic [NUM_SRC-1:0]            clr;
    logic [NUM_SRC-1:0]            pend;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        localparam bit IS_HOST = (s == SRC_HOST_OUT) || (s == SRC_HOST_IN);
        localparam bit IS_HI   = (s == SRC_HOST_IN)  || (s == SRC_LOC_OUT);
        localparam int SEL_LSB = IS_HI ? HI_SEL_LSB : LO_SEL_LSB;
        localparam int EN_BIT  = IS_HI ? HI_EN_BIT  : LO_EN_BIT;
        localparam int ST_BIT  = IS_HI ? ST_HI_BIT  : ST_LO_BIT;
        localparam int CFG_BE  = IS_HI ? 1 : 0;

        logic             own_wr;
        logic [DATA_W-1:0] own_data;
        logic [NB-1:0]    own_be;
        logic [NB-1:0]    far_be;
        logic             far_acc;
        logic [SEL_W-1:0] sel_r;
        logic             en_r;

        always_comb begin
            own_wr   = IS_HOST ? h_ct_wr : l_ct_wr;
            own_data = IS_HOST ? h_wdata : l_wdata;
            own_be   = IS_HOST ? h_be    : l_be;
            far_be   = IS_HOST ? l_be    : h_be;
            unique case (s)
                SRC_HOST_OUT: far_acc = l_mb_rd;
                SRC_HOST_IN:  far_acc = l_mb_wr;
                SRC_LOC_IN:   far_acc = h_mb_wr;
                default:      far_acc = h_mb_rd;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_r <= '0;
                en_r  <= 1'b0;
            end else if (own_wr && own_be[CFG_BE]) begin
                sel_r <= own_data[SEL_LSB +: SEL_W];
                en_r  <= own_data[EN_BIT];
            end
        end

        assign sel_q[s] = sel_r;
        assign en_q[s]  = en_r;
        assign hit[s]   = far_acc && far_be[sel_r];
        assign clr[s]   = own_wr && own_be[2] && own_data[ST_BIT];

        mbx_irq_src u_src (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit_i  (hit[s]),
            .clr_i  (clr[s]),
            .pend_o (pend[s])
        );
    end

    // interrupt lines
    mbx_irq_line #(.N_SRC(2)) u_host_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend[SRC_HOST_IN:SRC_HOST_OUT]),
        .en_i   (en_q[SRC_HOST_IN:SRC_HOST_OUT]),
        .irq_n  (h_irq_n)
    );

    mbx_irq_line #(.N_SRC(2)) u_loc_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend[SRC_LOC_OUT:SRC_LOC_IN]),
        .en_i   (en_q[SRC_LOC_OUT:SRC_LOC_IN]),
        .irq_n  (l_irq_n)
    );

    // read data
    logic [DATA_W-1:0] h_img, l_img;
    always_comb begin
        h_img = '0;
        h_img[LO_SEL_LSB +: SEL_W] = sel_q[SRC_HOST_OUT];
        h_img[LO_EN_BIT]           = en_q[SRC_HOST_OUT];
        h_img[HI_SEL_LSB +: SEL_W] = sel_q[SRC_HOST_IN];
        h_img[HI_EN_BIT]           = en_q[SRC_HOST_IN];
        h_img[ST_LO_BIT]           = pend[SRC_HOST_OUT];
        h_img[ST_HI_BIT]           = pend[SRC_HOST_IN];
        l_img = '0;
        l_img[LO_SEL_LSB +: SEL_W] = sel_q[SRC_LOC_IN];
        l_img[LO_EN_BIT]           = en_q[SRC_LOC_IN];
        l_img[HI_SEL_LSB +: SEL_W] = sel_q[SRC_LOC_OUT];
        l_img[HI_EN_BIT]           = en_q[SRC_LOC_OUT];
        l_img[ST_LO_BIT]           = pend[SRC_LOC_IN];
        l_img[ST_HI_BIT]           = pend[SRC_LOC_OUT];
        h_rdata = (h_addr == ADDR_CTRL) ? h_img : l2h_q;
        l_rdata = (l_addr == ADDR_CTRL) ? l_img : h2l_q;
    end

    AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_en && !l_en) |=> (pend == $past(pend))); // R11
    AST_H2L_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !h_mb_wr |=> $stable(h2l_q)); // R2
    AST_L2H_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !l_mb_wr |=> $stable(l2h_q)); // R2

endmodule

// File: tb/mbx_irq_ctrl_test.sv
module mbx_irq_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        h_en, h_wr, h_addr, l_en, l_wr, l_addr;
    logic [3:0]  h_be, l_be;
    logic [31:0] h_wdata, l_wdata, h_rdata, l_rdata;
    logic        h_irq_n, l_irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // model state; index 0 host-out, 1 host-in, 2 local-in, 3 local-out
    logic [31:0] m_h2l, m_l2h;
    logic [1:0]  m_sel [4];
    logic        m_en  [4];
    logic        m_st  [4];
    logic        exp_h_irq_n, exp_l_irq_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .h_en(h_en), .h_wr(h_wr), .h_addr(h_addr), .h_be(h_be),
        .h_wdata(h_wdata), .h_rdata(h_rdata),
        .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr), .l_be(l_be),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .h_irq_n(h_irq_n), .l_irq_n(l_irq_n)
    );

    function automatic logic [31:0] ctrl_img(input int a, input int b);
        logic [31:0] r;
        r = '0;
        r[1:0]  = m_sel[a];
        r[4]    = m_en[a];
        r[9:8]  = m_sel[b];
        r[12]   = m_en[b];
        r[16]   = m_st[a];
        r[17]   = m_st[b];
        return r;
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input logic he, input logic hw, input logic ha, input logic [3:0] hb,
                       input logic [31:0] hd,
                       input logic le, input logic lw, input logic la, input logic [3:0] lb,
                       input logic [31:0] ld);
        logic hit [4];
        logic clr [4];
        logic nh, nl;
        @(negedge clk);
        h_en = he; h_wr = hw; h_addr = ha; h_be = hb; h_wdata = hd;
        l_en = le; l_wr = lw; l_addr = la; l_be = lb; l_wdata = ld;
        #1;
        if (he && !hw) begin
            if (ha) check(h_rdata, ctrl_img(0, 1), "R3 R5 R6 R8 R9 R11 host ctrl");
            else    check(h_rdata, m_l2h, "R2 host mailbox read");
        end
        if (le && !lw) begin
            if (la) check(l_rdata, ctrl_img(2, 3), "R4 R7 R8 R9 R11 local ctrl");
            else    check(l_rdata, m_h2l, "R2 local mailbox read");
        end
        hit[0] = le && !lw && !la && lb[m_sel[0]];
        hit[1] = le &&  lw && !la && lb[m_sel[1]];
        hit[2] = he &&  hw && !ha && hb[m_sel[2]];
        hit[3] = he && !hw && !ha && hb[m_sel[3]];
        clr[0] = he && hw && ha && hb[2] && hd[16];
        clr[1] = he && hw && ha && hb[2] && hd[17];
        clr[2] = le && lw && la && lb[2] && ld[16];
        clr[3] = le && lw && la && lb[2] && ld[17];
        nh = !((m_st[0] && m_en[0]) || (m_st[1] && m_en[1]));
        nl = !((m_st[2] && m_en[2]) || (m_st[3] && m_en[3]));
        @(posedge clk);
        #1;
        for (int i = 0; i < 4; i++) m_st[i] = (m_st[i] && !clr[i]) || hit[i];
        if (he && hw && ha) begin
            if (hb[0]) begin m_sel[0] = hd[1:0]; m_en[0] = hd[4];  end
            if (hb[1]) begin m_sel[1] = hd[9:8]; m_en[1] = hd[12]; end
        end
        if (le && lw && la) begin
            if (lb[0]) begin m_sel[2] = ld[1:0]; m_en[2] = ld[4];  end
            if (lb[1]) begin m_sel[3] = ld[9:8]; m_en[3] = ld[12]; end
        end
        for (int b = 0; b < 4; b++) begin
            if (he && hw && !ha && hb[b]) m_h2l[8*b +: 8] = hd[8*b +: 8];
            if (le && lw && !la && lb[b]) m_l2h[8*b +: 8] = ld[8*b +: 8];
        end
        exp_h_irq_n = nh;
        exp_l_irq_n = nl;
        check({31'b0, h_irq_n}, {31'b0, exp_h_irq_n}, "R10 host irq");
        check({31'b0, l_irq_n}, {31'b0, exp_l_irq_n}, "R10 local irq");
    endtask

    task automatic idle();
        cyc(0, 0, 0, 4'h0, 32'h0, 0, 0, 0, 4'h0, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5a_77c3));
        rst_n = 1'b0;
        h_en = 0; h_wr = 0; h_addr = 0; h_be = 0; h_wdata = 0;
        l_en = 0; l_wr = 0; l_addr = 0; l_be = 0; l_wdata = 0;
        m_h2l = '0; m_l2h = '0;
        for (int i = 0; i < 4; i++) begin m_sel[i] = '0; m_en[i] = 0; m_st[i] = 0; end
        exp_h_irq_n = 1; exp_l_irq_n = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state at the ports
        check({31'b0, h_irq_n}, 32'd1, "R1 host irq after reset");
        check({31'b0, l_irq_n}, 32'd1, "R1 local irq after reset");
        check(h_rdata, 32'h0, "R1 host mailbox after reset");
        check(l_rdata, 32'h0, "R1 local mailbox after reset");
        cyc(1, 0, 1, 4'hF, 32'h0, 1, 0, 1, 4'hF, 32'h0);

        // R3 R4: both lane selects and enables set in one write per side
        cyc(1, 1, 1, 4'b0011, 32'h0000_1112, 1, 1, 1, 4'b0011, 32'h0000_0013);
        cyc(1, 0, 1, 4'hF, 32'h0, 1, 0, 1, 4'hF, 32'h0);
        // R5: read missing the selected lane (lane 2) sets nothing
        cyc(0, 0, 0, 4'h0, 32'h0, 1, 0, 0, 4'b0011, 32'h0);
        cyc(1, 0, 1, 4'hF, 32'h0, 0, 0, 0, 4'h0, 32'h0);
        // R5: read covering lane 2 sets host bit 16, irq follows (R10)
        cyc(0, 0, 0, 4'h0, 32'h0, 1, 0, 0, 4'b0100, 32'h0);
        idle();
        idle();
        cyc(1, 0, 1, 4'hF, 32'h0, 0, 0, 0, 4'h0, 32'h0);
        // R9: clear and event in the same cycle, set wins
        cyc(1, 1, 1, 4'b0100, 32'h0001_0000, 1, 0, 0, 4'b0100, 32'h0);
        cyc(1, 0, 1, 4'hF, 32'h0, 0, 0, 0, 4'h0, 32'h0);
        // R9: writing 0 leaves it, writing 1 clears it
        cyc(1, 1, 1, 4'b0100, 32'h0000_0000, 0, 0, 0, 4'h0, 32'h0);
        cyc(1, 1, 1, 4'b0100, 32'h0001_0000, 0, 0, 0, 4'h0, 32'h0);
        cyc(1, 0, 1, 4'hF, 32'h0, 0, 0, 0, 4'h0, 32'h0);
        // R7 R2: host writes lane 3 of host-to-local mailbox
        cyc(1, 1, 0, 4'b1000, 32'hA500_0000, 0, 0, 0, 4'h0, 32'h0);
        cyc(0, 0, 0, 4'h0, 32'h0, 1, 0, 0, 4'hF, 32'h0);
        cyc(0, 0, 0, 4'h0, 32'h0, 1, 0, 1, 4'hF, 32'h0);
        // R6 R8: local write to selected lane while source disabled still latches
        cyc(1, 1, 1, 4'b0010, 32'h0000_0100, 1, 1, 0, 4'b0010, 32'h0000_3C00);
        cyc(1, 0, 1, 4'hF, 32'h0, 0, 0, 0, 4'h0, 32'h0);
        // R11: control accesses and strobe-low accesses never latch events
        cyc(0, 1, 0, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 4'hF, 32'h0);
        cyc(1, 0, 1, 4'hF, 32'h0, 1, 0, 1, 4'hF, 32'h0);

        for (int n = 0; n < N_RANDOM; n++) begin
            logic he, hw, ha, le, lw, la;
            logic [3:0] hb, lb;
            logic [31:0] hd, ld;
            he = ($urandom % 3) != 0;
            hw = $urandom % 2;
            ha = ($urandom % 4) == 0;
            hb = 4'($urandom);
            hd = $urandom;
            le = ($urandom % 3) != 0;
            lw = $urandom % 2;
            la = ($urandom % 4) == 0;
            lb = 4'($urandom);
            ld = $urandom;
            cyc(he, hw, ha, hb, hd, le, lw, la, lb, ld);
        end
        idle();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule